// File: doc/BRIEF.md
# PWM Event Qualifier with Continuous Force

This block sits between a time-base counter and two PWM pins. On every clock it takes the counter's event strobes: counter reached zero, counter reached period, counter matched compare A while counting up, and counter matched compare B while counting up. It turns them into the next level of each output, A and B. Each output has its own 16-bit action word. For every event, the word selects one of four actions: leave the pin alone, drive it low, drive it high or toggle it. Normal or inverted waveform polarity comes only from the contents of the action word.

A continuous software force sits above the event logic. It can pin either output low or high for as long as it stays active. The force-control word is not applied directly. It is copied into an active force register at a reload point chosen by a 2-bit mode: counter zero, counter period, either of the two, or the next clock. Software can therefore change the force in step with the PWM period. When a force is released, the pin keeps its level until the next event that acts on it.

Top module: `pwm_evt_qualifier`

## Requirements
- R1: While reset is asserted and after it is released, both outputs are low and no force is active.
- R2: In an action word, bits 1:0 act on the zero event, bits 3:2 on the period event, bits 5:4 on the compare-A-up event and bits 9:8 on the compare-B-up event. The code 00 does nothing, 01 drives low, 10 drives high and 11 toggles. The output register takes the new level at the clock edge that samples the strobe.
- R3: The action word 0x001A on A (high at zero and period, low at compare A) gives normal polarity. The word 0x0025 gives the inverted waveform. For B, the matching words are 0x010A and 0x0205, which use compare B.
- R4: When no force is active or loading, a clock edge with no event strobe leaves both outputs unchanged.
- R5: When several strobes arrive in one cycle, only events whose action code is not 00 compete. Priority runs compare B, then compare A, then period, then zero.
- R6: Bits 7:6 and 15:10 of an action word have no effect.
- R7: Force word bits 1:0 control A and bits 3:2 control B. The code 01 forces low, 10 forces high, and 00 or 11 mean no force. An active force overrides every event action on its output.
- R8: Reload mode 00 loads the force word on a zero strobe, 01 on a period strobe, 10 on either, and 11 on every clock. The loaded value already decides the output at the loading edge. Until the next load, the previously active force applies.
- R9: When a force is released, the output keeps its forced level until an event with a non-zero action changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_zero | input | 1 | Counter-at-zero strobe |
| ev_period | input | 1 | Counter-at-period strobe |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| act_a | input | 16 | Event action word for output A |
| act_b | input | 16 | Event action word for output B |
| frc_word | input | 4 | Requested continuous force, A at 1:0, B at 3:2 |
| reload_sel | input | 2 | Reload point for the force word |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bound checker checks four rules on every cycle. An output holds its level when no event arrives and no force is active. An active high force holds its pin. Immediate reload applies a low force on the next edge. A compare action beats a period action in the same cycle. The directed scenarios are the only place that shows the complete waveforms for each polarity. They also cover toggling, the order of coincident events, the unused bits of the action word, every reload mode timed against zero and period strobes, and the release of a force that leaves the pin where it was.

// File: rtl/pwm_evt_qualifier.sv
module pwm_evt_qualifier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_zero,
  input  logic        ev_period,
  input  logic        ev_cmpa_up,
  input  logic        ev_cmpb_up,
  input  logic [15:0] act_a,
  input  logic [15:0] act_b,
  input  logic [3:0]  frc_word,
  input  logic [1:0]  reload_sel,
  output logic        pwm_a,
  output logic        pwm_b
);

  logic [3:0] frc_act;
  logic       frc_load;
  logic [3:0] frc_eff;

  function automatic logic next_lvl(input logic cur, input logic [15:0] w,
                                    input logic ez, input logic ep,
                                    input logic ea, input logic eb);
    logic [1:0] a;
    a = 2'b00;
    if (ez && w[1:0] != 2'b00) a = w[1:0];
    if (ep && w[3:2] != 2'b00) a = w[3:2];
    if (ea && w[5:4] != 2'b00) a = w[5:4];
    if (eb && w[9:8] != 2'b00) a = w[9:8];
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic apply_frc(input logic [1:0] f, input logic lvl);
    case (f)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return lvl;
    endcase
  endfunction

  always_comb begin
    case (reload_sel)
      2'b00:   frc_load = ev_zero;
      2'b01:   frc_load = ev_period;
      2'b10:   frc_load = ev_zero | ev_period;
      default: frc_load = 1'b1;
    endcase
  end

  assign frc_eff = frc_load ? frc_word : frc_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_act <= 4'b0000;
      pwm_a   <= 1'b0;
      pwm_b   <= 1'b0;
    end else begin
      frc_act <= frc_eff;
      pwm_a   <= apply_frc(frc_eff[1:0],
                   next_lvl(pwm_a, act_a, ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up));
      pwm_b   <= apply_frc(frc_eff[3:2],
                   next_lvl(pwm_b, act_b, ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up));
    end
  end

endmodule

// File: rtl/pwm_evt_qualifier_chk.sv
module pwm_evt_qualifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_zero,
  input logic        ev_period,
  input logic        ev_cmpa_up,
  input logic        ev_cmpb_up,
  input logic [15:0] act_a,
  input logic [3:0]  frc_word,
  input logic [1:0]  reload_sel,
  input logic [3:0]  frc_act,
  input logic        pwm_a,
  input logic        pwm_b
);

  logic no_ev;
  assign no_ev = !ev_zero && !ev_period && !ev_cmpa_up && !ev_cmpb_up;

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ev && reload_sel != 2'b11 && (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11))
      |=> $stable(pwm_a));

  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b10 && reload_sel != 2'b11 && !ev_zero && !ev_period) |=> pwm_a);

  // R8
  imm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_sel == 2'b11 && frc_word[3:2] == 2'b01) |=> !pwm_b);

  // R5
  cmp_over_prd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_sel == 2'b00 && !ev_zero && ev_period && ev_cmpa_up && !ev_cmpb_up &&
     act_a[5:4] == 2'b01 && act_a[3:2] == 2'b10 &&
     (frc_act[1:0] == 2'b00 || frc_act[1:0] == 2'b11)) |=> !pwm_a);

endmodule

bind pwm_evt_qualifier pwm_evt_qualifier_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .ev_period(ev_period),
  .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up), .act_a(act_a),
  .frc_word(frc_word), .reload_sel(reload_sel), .frc_act(frc_act),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/test_pwm_evt_qualifier.sv
module test_pwm_evt_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic [15:0] act_a = 16'h0, act_b = 16'h0;
  logic [3:0]  frc_word = 4'h0;
  logic [1:0]  reload_sel = 2'b00;
  logic pwm_a, pwm_b;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_evt_qualifier i_pwm_evt_qualifier (
    .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up), .act_a(act_a), .act_b(act_b),
    .frc_word(frc_word), .reload_sel(reload_sel), .pwm_a(pwm_a), .pwm_b(pwm_b));

  task automatic chk(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic z, input logic p, input logic a, input logic b);
    @(negedge clk);
    ev_zero = z; ev_period = p; ev_cmpa_up = a; ev_cmpb_up = b;
    @(posedge clk);
    #1;
    ev_zero = 0; ev_period = 0; ev_cmpa_up = 0; ev_cmpb_up = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset A", pwm_a, 1'b0);
    chk("R1 reset B", pwm_b, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk("R1 after release A", pwm_a, 1'b0);
    chk("R1 after release B", pwm_b, 1'b0);
  endtask

  task automatic t_normal;
    act_a = 16'h001A; act_b = 16'h010A;
    step(1, 0, 0, 0); chk("R3 normal zero A", pwm_a, 1); chk("R3 normal zero B", pwm_b, 1);
    step(0, 0, 1, 0); chk("R2 cmpA low A", pwm_a, 0);    chk("R2 cmpA no act B", pwm_b, 1);
    step(0, 0, 0, 1); chk("R2 cmpB low B", pwm_b, 0);    chk("R2 cmpB no act A", pwm_a, 0);
    step(0, 0, 0, 0); chk("R4 idle A", pwm_a, 0);        chk("R4 idle B", pwm_b, 0);
    step(0, 1, 0, 0); chk("R3 period high A", pwm_a, 1); chk("R3 period high B", pwm_b, 1);
  endtask

  task automatic t_inverted;
    act_a = 16'h0025; act_b = 16'h0205;
    step(1, 0, 0, 0); chk("R3 inv zero A", pwm_a, 0); chk("R3 inv zero B", pwm_b, 0);
    step(0, 0, 1, 0); chk("R3 inv cmpA A", pwm_a, 1); chk("R3 inv cmpA B", pwm_b, 0);
    step(0, 0, 0, 1); chk("R3 inv cmpB B", pwm_b, 1);
    act_b = 16'h0000;
  endtask

  task automatic t_toggle;
    act_a = 16'h0003;
    step(1, 0, 0, 0); chk("R2 toggle 1", pwm_a, 0);
    step(1, 0, 0, 0); chk("R2 toggle 2", pwm_a, 1);
    step(0, 0, 0, 0); chk("R4 hold after toggle", pwm_a, 1);
  endtask

  task automatic t_priority;
    act_a = 16'h0018;
    step(0, 1, 1, 0); chk("R5 cmpA over period", pwm_a, 0);
    act_a = 16'h0009;
    step(1, 1, 0, 0); chk("R5 period over zero", pwm_a, 1);
    act_a = 16'h0001;
    step(1, 1, 0, 0); chk("R5 period without action yields", pwm_a, 0);
    act_a = 16'h0210;
    step(0, 0, 1, 1); chk("R5 cmpB over cmpA", pwm_a, 1);
  endtask

  task automatic t_ignored;
    act_a = 16'hFCC0;
    step(1, 0, 0, 0); chk("R6 unused bits zero", pwm_a, 1);
    step(1, 1, 1, 1); chk("R6 unused bits all events", pwm_a, 1);
    act_a = 16'h00C1;
    step(1, 0, 0, 0); chk("R6 zero field still acts", pwm_a, 0);
  endtask

  task automatic t_force;
    act_a = 16'h001A; act_b = 16'h0205;
    reload_sel = 2'b00;
    step(1, 0, 0, 0); chk("R3 setup A", pwm_a, 1); chk("R3 setup B", pwm_b, 0);
    frc_word = 4'b0001;
    step(0, 0, 0, 0); chk("R8 zero mode not yet loaded", pwm_a, 1);
    step(1, 0, 0, 0); chk("R8 loaded at zero, forced low", pwm_a, 0);
    step(0, 1, 0, 0); chk("R7 force beats period high", pwm_a, 0);
    reload_sel = 2'b01; frc_word = 4'b0000;
    step(1, 0, 0, 0); chk("R8 period mode ignores zero", pwm_a, 0);
    step(0, 1, 0, 0); chk("R8 released at period", pwm_a, 1);
    reload_sel = 2'b10; frc_word = 4'b1000;
    step(0, 0, 0, 0); chk("R8 either mode waits", pwm_b, 0);
    step(0, 1, 0, 0); chk("R8 either mode loads at period", pwm_b, 1);
    step(1, 0, 0, 0); chk("R7 force B high beats zero low", pwm_b, 1);
    reload_sel = 2'b11; frc_word = 4'b0100;
    step(0, 0, 0, 0); chk("R8 immediate load B low", pwm_b, 0);
    chk("R7 A unaffected by B force", pwm_a, 1);
    frc_word = 4'b1100;
    step(0, 0, 0, 0); chk("R9 release keeps level", pwm_b, 0);
    step(0, 0, 0, 1); chk("R7 code 11 lets cmpB act", pwm_b, 1);
    frc_word = 4'b0000; reload_sel = 2'b00;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_inverted();
    t_toggle();
    t_priority();
    t_ignored();
    t_force();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule